// File: doc/BRIEF.md
# ADC Result Post-Processor

This block sits behind an ADC front end and turns its stream of conversion results into a processed value. A 3-bit mode input picks one of five treatments. Pass-through forwards each result. Accumulate sums results. Average and burst average produce a scaled mean over a programmed number of samples. The low-pass mode runs a first-order filter. A 3-bit shift input scales the result in the summing modes and sets the time constant of the filter.

Each processed value appears on `res_out` together with a one-cycle `done` pulse. The running sum, the sticky overflow flag and the sample count are visible at all times. A clear command zeroes them, and its busy flag drops when the hardware has finished. At every start-of-conversion strobe, a previous-sample register captures either the last raw result or the low bits of the processed value.

Top module: `adc_post_proc`

## Requirements
- R1: After reset, `acc_out`, `cnt_out`, `res_out`, `prev_out`, `ovf`, `done` and `clr_busy` are all zero.
- R2: Mode code 000 (basic), and the reserved codes 101, 110 and 111, copy each accepted sample to `res_out` with a `done` pulse. The shift input has no effect, and `acc_out` and `cnt_out` do not change.
- R3: Mode 001 (accumulate) adds each sample to `acc_out` and increments `cnt_out`, saturating at its maximum. It outputs `(acc + sample) >> shift` with a `done` pulse for every sample.
- R4: Mode 010 (average) accumulates samples and counts them. On the sample that makes the count reach `cfg_repeat`, it outputs `sum >> shift` with `done` and returns the accumulator and count to zero. Earlier samples give no `done`.
- R5: Mode 011 (burst average) ignores samples until a `conv_start` strobe arms it. It then averages as in R4 and disarms on completion. Samples that arrive while it is disarmed are ignored.
- R6: A `clr_req` pulse raises `clr_busy` in the next cycle. In that busy cycle the accumulator, overflow flag and count are zeroed, and `clr_busy` drops at the following edge. A sample presented while `clr_busy` is 1 is discarded.
- R7: Mode 100 (low-pass) updates `acc <= acc + sample - (acc >> shift)` and outputs `new_acc >> shift` with `done` for every sample. This gives a time constant of 2^shift and unity gain.
- R8: `ovf` sets when a sum in modes 001, 010 or 011 carries out of the accumulator width (`RES_W + 7` bits). It stays set until a clear.
- R9: The reserved shift value 7 acts as a shift of 6.
- R10: On `conv_start`, `prev_out` loads `res_out[RES_W-1:0]` when `cfg_prev_sel` is 1, and otherwise the last accepted raw sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | Conversion result valid |
| res_data | input | RES_W | Conversion result |
| conv_start | input | 1 | Start-of-conversion strobe |
| cfg_mode | input | 3 | Computation mode code |
| cfg_shift | input | 3 | Right-shift / filter time-constant select |
| cfg_repeat | input | CNT_W | Samples per average set |
| cfg_prev_sel | input | 1 | Previous-sample source (1 = processed value) |
| clr_req | input | 1 | Clear command pulse |
| clr_busy | output | 1 | Clear command pending |
| acc_out | output | RES_W+7 | Accumulator |
| res_out | output | RES_W+7 | Processed value |
| cnt_out | output | CNT_W | Sample counter |
| ovf | output | 1 | Sticky overflow |
| prev_out | output | RES_W | Previous-sample register |
| done | output | 1 | Result-ready pulse |

## Verification
The clear command and an incoming sample can land in the same cycle. The bench provokes this by raising `res_valid` in exactly the cycle where `clr_busy` is high. It judges the outcome by requiring that no `done` pulse reaches the scoreboard and that `acc_out` and `cnt_out` read zero afterwards. Average completion and automatic accumulator reset also coincide with the accepting sample. This is judged by the scoreboard value together with a zero accumulator read on the next cycle.

// File: rtl/adcpp_pkg.sv
// Shared types and helpers for the ADC result post-processor.
// Assumes the mode and shift fields are exactly 3 bits wide.
package adcpp_pkg;

    typedef enum logic [2:0] {
        MODE_BASIC = 3'b000,
        MODE_ACCUM = 3'b001,
        MODE_AVG   = 3'b010,
        MODE_BURST = 3'b011,
        MODE_LPF   = 3'b100
    } mode_e;

    // Map a raw mode code to a mode; reserved codes fall back to basic.
    function automatic mode_e decode_mode(input logic [2:0] raw);
        case (raw)
            3'b001:  return MODE_ACCUM;
            3'b010:  return MODE_AVG;
            3'b011:  return MODE_BURST;
            3'b100:  return MODE_LPF;
            default: return MODE_BASIC;
        endcase
    endfunction

    // Map the raw shift code; the reserved value 7 is treated as 6.
    function automatic logic [2:0] eff_shift(input logic [2:0] raw);
        return (raw == 3'd7) ? 3'd6 : raw;
    endfunction

endpackage

// File: rtl/adcpp_ctrl.sv
// Sequencing for the post-processor: sample acceptance, sample counter,
// burst arming, clear handshake and the done pulse.
// Assumes the mode input is already decoded (reserved codes mapped).
module adcpp_ctrl
    import adcpp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode,
    input  logic             res_valid,
    input  logic             conv_start,
    input  logic             clr_req,
    input  logic [CNT_W-1:0] cfg_repeat,
    output logic             take,
    output logic             complete,
    output logic             clr_busy,
    output logic             done,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             armed_q;
    logic [CNT_W:0]   cnt_inc;
    logic             is_avg;

    assign is_avg   = (mode == MODE_AVG) || (mode == MODE_BURST);
    assign take     = res_valid && !clr_busy && ((mode != MODE_BURST) || armed_q);
    assign cnt_inc  = {1'b0, cnt} + 1'b1;
    assign complete = take && is_avg && (cnt_inc >= {1'b0, cfg_repeat});

    // Clear handshake: set on request, drop after the one clearing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        clr_busy <= 1'b0;
        else if (clr_busy) clr_busy <= 1'b0;
        else if (clr_req)  clr_busy <= 1'b1;
    end

    // Sample counter: cleared by command, advanced per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_busy) begin
            cnt <= '0;
        end else if (take) begin
            case (mode)
                MODE_ACCUM:           cnt <= (cnt == CNT_MAX) ? cnt : cnt_inc[CNT_W-1:0];
                MODE_AVG, MODE_BURST: cnt <= complete ? '0 : cnt_inc[CNT_W-1:0];
                default:              cnt <= cnt;
            endcase
        end
    end

    // Burst arming: a strobe arms, a completed set disarms.
    always_ff @(posedge clk) begin
        if (!rst_n || mode != MODE_BURST) armed_q <= 1'b0;
        else if (complete)                armed_q <= 1'b0;
        else if (conv_start)              armed_q <= 1'b1;
    end

    // Done pulse: every accepted sample, except averaging sets mid-way.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= take && (!is_avg || complete);
    end

    // R6: the busy flag lasts exactly one cycle
    a_r6_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy |=> !clr_busy);

    // R4: a completed set leaves the counter at zero
    a_r4_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (cnt == '0));

endmodule

// File: rtl/adcpp_accum.sv
// Accumulator datapath: summing, low-pass update, overflow and result.
// Assumes take/complete/clr come from adcpp_ctrl and that clr wins over take.
module adcpp_accum
    import adcpp_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int ACC_W = RES_W + 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode,
    input  logic [2:0]       shift,
    input  logic             take,
    input  logic             complete,
    input  logic             clr,
    input  logic [RES_W-1:0] sample,
    output logic [ACC_W-1:0] acc,
    output logic             ovf,
    output logic [ACC_W-1:0] res
);

    logic [ACC_W:0]   sum_w;
    logic [ACC_W:0]   lpf_w;
    logic [ACC_W-1:0] sum_v;
    logic [ACC_W-1:0] lpf_v;

    assign sum_w = {1'b0, acc} + {{(ACC_W+1-RES_W){1'b0}}, sample};
    assign lpf_w = sum_w - {1'b0, (acc >> shift)};
    assign sum_v = sum_w[ACC_W-1:0];
    assign lpf_v = lpf_w[ACC_W-1:0];

    // Accumulator and overflow: cleared by command, updated per mode.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
            ovf <= 1'b0;
        end else if (take) begin
            case (mode)
                MODE_ACCUM: begin
                    acc <= sum_v;
                    ovf <= ovf | sum_w[ACC_W];
                end
                MODE_AVG, MODE_BURST: begin
                    acc <= complete ? '0 : sum_v;
                    ovf <= ovf | sum_w[ACC_W];
                end
                MODE_LPF: acc <= lpf_v;
                default:  acc <= acc;
            endcase
        end
    end

    // Result register: the processed value of the accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res <= '0;
        end else if (take && !clr) begin
            case (mode)
                MODE_ACCUM:           res <= sum_v >> shift;
                MODE_AVG, MODE_BURST: res <= complete ? (sum_v >> shift) : res;
                MODE_LPF:             res <= lpf_v >> shift;
                default:              res <= {{(ACC_W-RES_W){1'b0}}, sample};
            endcase
        end
    end

    // R8: overflow is sticky until a clear
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

    // R2: basic mode leaves the accumulator untouched
    a_r2_basic_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clr && mode == MODE_BASIC) |=> $stable(acc));

endmodule

// File: rtl/adcpp_prev.sv
// Previous-sample capture: tracks the last raw sample and loads the
// previous-sample register at each conversion start.
// Assumes take marks only samples actually accepted by the unit.
module adcpp_prev #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic             prev_sel,
    input  logic             take,
    input  logic [RES_W-1:0] sample,
    input  logic [RES_W-1:0] filt_low,
    output logic [RES_W-1:0] prev
);

    logic [RES_W-1:0] last_raw;

    // Last raw sample register.
    always_ff @(posedge clk) begin
        if (!rst_n)    last_raw <= '0;
        else if (take) last_raw <= sample;
    end

    // Previous-sample register loaded at start of conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)          prev <= '0;
        else if (conv_start) prev <= prev_sel ? filt_low : last_raw;
    end

    // R10: prev only moves on a conversion start
    a_r10_prev_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |=> $stable(prev));

endmodule

// File: rtl/adc_post_proc.sv
// Top of the ADC result post-processor: decodes configuration and joins
// the control, accumulator and previous-sample pieces.
// Assumes configuration inputs are held steady while a set is in progress.
module adc_post_proc
    import adcpp_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int CNT_W = 8,
    parameter int GUARD = 7,
    localparam int ACC_W = RES_W + GUARD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    input  logic             conv_start,
    input  logic [2:0]       cfg_mode,
    input  logic [2:0]       cfg_shift,
    input  logic [CNT_W-1:0] cfg_repeat,
    input  logic             cfg_prev_sel,
    input  logic             clr_req,
    output logic             clr_busy,
    output logic [ACC_W-1:0] acc_out,
    output logic [ACC_W-1:0] res_out,
    output logic [CNT_W-1:0] cnt_out,
    output logic             ovf,
    output logic [RES_W-1:0] prev_out,
    output logic             done
);

    mode_e      mode;
    logic [2:0] shift;
    logic       take;
    logic       complete;

    assign mode  = decode_mode(cfg_mode);
    assign shift = (mode == MODE_BASIC) ? 3'd0 : eff_shift(cfg_shift);

    adcpp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .res_valid  (res_valid),
        .conv_start (conv_start),
        .clr_req    (clr_req),
        .cfg_repeat (cfg_repeat),
        .take       (take),
        .complete   (complete),
        .clr_busy   (clr_busy),
        .done       (done),
        .cnt        (cnt_out)
    );

    adcpp_accum #(.RES_W(RES_W), .ACC_W(ACC_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .shift    (shift),
        .take     (take),
        .complete (complete),
        .clr      (clr_busy),
        .sample   (res_data),
        .acc      (acc_out),
        .ovf      (ovf),
        .res      (res_out)
    );

    adcpp_prev #(.RES_W(RES_W)) u_prev (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .prev_sel   (cfg_prev_sel),
        .take       (take),
        .sample     (res_data),
        .filt_low   (res_out[RES_W-1:0]),
        .prev       (prev_out)
    );

    // R6: the clearing cycle leaves accumulator, count and overflow at zero
    a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy |=> (acc_out == '0 && cnt_out == '0 && !ovf));

    // R6: a sample offered while clearing produces no result
    a_r6_busy_drops_sample: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy |=> !done);

endmodule

// File: tb/adc_post_proc_tb_top.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// them on each done pulse and compares against res_out.
module adc_post_proc_tb_top;

    localparam int RES_W = 10;
    localparam int CNT_W = 8;
    localparam int ACC_W = RES_W + 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             res_valid = 1'b0;
    logic [RES_W-1:0] res_data = '0;
    logic             conv_start = 1'b0;
    logic [2:0]       cfg_mode = 3'd0;
    logic [2:0]       cfg_shift = 3'd0;
    logic [CNT_W-1:0] cfg_repeat = '0;
    logic             cfg_prev_sel = 1'b0;
    logic             clr_req = 1'b0;
    logic             clr_busy;
    logic [ACC_W-1:0] acc_out;
    logic [ACC_W-1:0] res_out;
    logic [CNT_W-1:0] cnt_out;
    logic             ovf;
    logic [RES_W-1:0] prev_out;
    logic             done;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    longint exp_q[$];

    always #5 clk = ~clk;

    adc_post_proc dut_i (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .conv_start(conv_start), .cfg_mode(cfg_mode), .cfg_shift(cfg_shift),
        .cfg_repeat(cfg_repeat), .cfg_prev_sel(cfg_prev_sel), .clr_req(clr_req),
        .clr_busy(clr_busy), .acc_out(acc_out), .res_out(res_out),
        .cnt_out(cnt_out), .ovf(ovf), .prev_out(prev_out), .done(done)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one sample per call; expected result queued when due.
    task automatic smp(input int v, input bit expd, input longint e);
        @(negedge clk);
        res_valid = 1'b1;
        res_data  = RES_W'(v);
        if (expd) exp_q.push_back(e);
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe(input bit sel);
        @(negedge clk);
        cfg_prev_sel = sel;
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
    endtask

    // Monitor: compare every done pulse against the scoreboard.
    always @(posedge clk) begin
        #2;
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL scoreboard unexpected done actual=%0d expected=none", res_out);
            end else begin
                chk("scoreboard result", res_out, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 acc", acc_out, 0);
        chk("R1 cnt", cnt_out, 0);
        chk("R1 res", res_out, 0);
        chk("R1 flags", {ovf, done, clr_busy}, 0);
        chk("R1 prev", prev_out, 0);
        rst_n = 1'b1;

        // R2: basic mode, shift ignored, acc untouched
        cfg_mode = 3'b000; cfg_shift = 3'd5;
        smp(100, 1, 100);
        chk("R2 acc unchanged", acc_out, 0);
        cfg_mode = 3'b110;
        smp(77, 1, 77);
        chk("R2 reserved mode cnt", cnt_out, 0);

        // R3: accumulate with shift 1
        cfg_mode = 3'b001; cfg_shift = 3'd1;
        smp(10, 1, 5);
        smp(20, 1, 15);
        smp(31, 1, 30);
        chk("R3 acc", acc_out, 61);
        chk("R3 cnt", cnt_out, 3);

        // R6: clear with a sample colliding in the busy cycle
        @(negedge clk);
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        chk("R6 busy raised", clr_busy, 1);
        res_valid = 1'b1; res_data = 10'd50;
        @(negedge clk);
        res_valid = 1'b0;
        chk("R6 busy dropped", clr_busy, 0);
        chk("R6 acc cleared", acc_out, 0);
        chk("R6 cnt cleared", cnt_out, 0);

        // R4: average of 4 samples with shift 2
        cfg_mode = 3'b010; cfg_shift = 3'd2; cfg_repeat = 8'd4;
        smp(4, 0, 0);
        smp(8, 0, 0);
        smp(12, 0, 0);
        chk("R4 partial acc", acc_out, 24);
        chk("R4 partial cnt", cnt_out, 3);
        smp(16, 1, 10);
        chk("R4 acc restarted", acc_out, 0);
        chk("R4 cnt restarted", cnt_out, 0);

        // R5: burst average needs a trigger
        cfg_mode = 3'b011; cfg_shift = 3'd1; cfg_repeat = 8'd2;
        smp(99, 0, 0);
        chk("R5 idle sample ignored", acc_out, 0);
        strobe(1'b0);
        smp(6, 0, 0);
        smp(10, 1, 8);
        smp(5, 0, 0);
        chk("R5 disarmed sample ignored", acc_out, 0);

        // R7: low-pass filter with shift 1
        do_clear();
        cfg_mode = 3'b100; cfg_shift = 3'd1;
        smp(100, 1, 50);
        smp(100, 1, 75);
        smp(100, 1, 87);
        chk("R7 filter state", acc_out, 175);

        // R8: overflow after 129 full-scale samples
        do_clear();
        cfg_mode = 3'b001; cfg_shift = 3'd0;
        for (int k = 1; k <= 128; k++) smp(1023, 1, (k * 1023) % 131072);
        chk("R8 no overflow yet", ovf, 0);
        smp(1023, 1, (129 * 1023) % 131072);
        chk("R8 overflow set", ovf, 1);
        chk("R3 count", cnt_out, 129);
        smp(1, 1, ((129 * 1023) % 131072) + 1);
        chk("R8 overflow sticky", ovf, 1);
        do_clear();
        chk("R8 overflow cleared", ovf, 0);

        // R9: reserved shift 7 acts as 6
        cfg_shift = 3'd7;
        smp(640, 1, 10);

        // R10: previous-sample source select
        do_clear();
        cfg_shift = 3'd1;
        smp(300, 1, 150);
        strobe(1'b1);
        chk("R10 prev from result", prev_out, 150);
        strobe(1'b0);
        chk("R10 prev from raw", prev_out, 300);

        repeat (3) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule